// File: doc/BRIEF.md
# Floating-Point Three-Way Comparator

This block orders two 64-bit operands and reports the outcome as a signed 32-bit value: -1 when the first operand is below the second, 0 when they are equal, +1 when it is above. The operands are read as two single-precision floats, two double-precision floats, or two signed 64-bit integers, chosen by a mode input. In the float modes, an unordered pair (one or both operands NaN) has no natural answer. A bias input decides whether such a pair reports +1 or -1. One compare primitive can then serve a "less than" test (high bias, test for -1) and a "greater than" test (low bias, test for +1), and a NaN makes either test come out false.

A request is presented with `in_valid_i` high. The result and `out_valid_o` appear one clock later from a register. The result register holds its value while no request is presented.

Top module: `fp_tricmp`

## Requirements
- R1: `mode_i` selects the operand format: 2'b00 is single precision in bits [31:0], 2'b01 is double precision in bits [63:0], and 2'b10 or 2'b11 is signed 64-bit integer.
- R2: Equal ordered operands give 32'h0000_0000.
- R3: An ordered first operand below the second gives 32'hFFFF_FFFF (-1). One above the second gives 32'h0000_0001 (+1).
- R4: In a float mode with `bias_hi_i`=1, a pair with any NaN gives +1. A NaN has an all-ones exponent and a nonzero fraction, and both quiet and signalling forms count.
- R5: In a float mode with `bias_hi_i`=0, a pair with any NaN gives -1, whichever operand is the NaN.
- R6: Positive zero and negative zero compare equal.
- R7: An infinity ranks beyond every finite value of its sign, and it equals an infinity of the same sign.
- R8: Integer mode uses two's-complement order over all 64 bits, has no unordered case, and ignores `bias_hi_i`.
- R9: `out_valid_o` is high exactly in the cycle after a cycle with `in_valid_i` high. Back-to-back requests give back-to-back results.
- R10: During and just after reset, `out_valid_o` is 0 and `result_o` is 0.
- R11: `result_o` holds its last value in every cycle that follows a cycle without a request.
- R12: In single-precision mode, bits [63:32] of both operands have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe |
| mode_i | input | 2 | Operand format select |
| bias_hi_i | input | 1 | 1: unordered reports +1, 0: unordered reports -1 |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| out_valid_o | output | 1 | Result valid, one cycle after the request |
| result_o | output | 32 | Signed three-way result |

## Verification
The hardest cases to reach are those where the operand's bit pattern and its meaning disagree. Examples are a double-width word whose low half is a single-precision NaN, a signalling NaN with only the lowest fraction bit set, an integer whose bits would be a NaN as a float, and two zeros of opposite sign. The vector table places each of these beside an ordinary value, with both bias settings, so that a lane that looks at the wrong bits or folds the sign the wrong way shows up as a wrong result value. Directed steps then hold the request low and pulse reset, to check the hold and clear behaviour.

// File: rtl/fp_tricmp_pkg.sv
package fp_tricmp_pkg;

   typedef enum logic [1:0] {
      ORD_LT = 2'b00,
      ORD_EQ = 2'b01,
      ORD_GT = 2'b10,
      ORD_UN = 2'b11
   } order_e;

   localparam logic [1:0] MODE_SP = 2'b00;
   localparam logic [1:0] MODE_DP = 2'b01;

endpackage

// File: rtl/fp_classify.sv
module fp_classify #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int FULL_W = 1 + EXP_W + MAN_W,
   localparam int MAG_W  = EXP_W + MAN_W
) (
   input  logic [FULL_W-1:0] val_i,
   output logic              nan_o,
   output logic              zero_o,
   output logic              sign_o,
   output logic [MAG_W-1:0]  mag_o
);

   if (EXP_W < 2 || MAN_W < 1) begin : g_bad_fmt
      $error("fp_classify: exponent or fraction width too small");
   end

   logic [EXP_W-1:0] expo;
   logic [MAN_W-1:0] frac;

   assign sign_o = val_i[FULL_W-1];
   assign expo   = val_i[MAG_W-1:MAN_W];
   assign frac   = val_i[MAN_W-1:0];
   assign mag_o  = val_i[MAG_W-1:0];
   assign nan_o  = (&expo) && (|frac);
   assign zero_o = ~|val_i[MAG_W-1:0];

endmodule

// File: rtl/fp_order.sv
module fp_order
   import fp_tricmp_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int FULL_W = 1 + EXP_W + MAN_W,
   localparam int MAG_W  = EXP_W + MAN_W
) (
   input  logic [FULL_W-1:0] a_i,
   input  logic [FULL_W-1:0] b_i,
   output order_e            ord_o
);

   logic             a_nan, a_zero, a_sign;
   logic             b_nan, b_zero, b_sign;
   logic [MAG_W-1:0] a_mag, b_mag;

   fp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (
      .val_i (a_i),
      .nan_o (a_nan),
      .zero_o(a_zero),
      .sign_o(a_sign),
      .mag_o (a_mag)
   );

   fp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (
      .val_i (b_i),
      .nan_o (b_nan),
      .zero_o(b_zero),
      .sign_o(b_sign),
      .mag_o (b_mag)
   );

   // Sign-magnitude ordering: magnitudes order directly with the exponent
   // on top, and for two negatives the sense is reversed.
   always_comb begin
      if (a_nan || b_nan) begin
         ord_o = ORD_UN;
      end else if (a_zero && b_zero) begin
         ord_o = ORD_EQ;
      end else if (a_sign != b_sign) begin
         ord_o = a_sign ? ORD_LT : ORD_GT;
      end else if (a_mag == b_mag) begin
         ord_o = ORD_EQ;
      end else if ((a_mag < b_mag) ^ a_sign) begin
         ord_o = ORD_LT;
      end else begin
         ord_o = ORD_GT;
      end
   end

endmodule

// File: rtl/int_order.sv
module int_order
   import fp_tricmp_pkg::*;
#(
   parameter int W = 64
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output order_e       ord_o
);

   if (W < 2) begin : g_bad_w
      $error("int_order: width too small");
   end

   always_comb begin
      if (a_i == b_i) begin
         ord_o = ORD_EQ;
      end else if ($signed(a_i) < $signed(b_i)) begin
         ord_o = ORD_LT;
      end else begin
         ord_o = ORD_GT;
      end
   end

endmodule

// File: rtl/fp_tricmp.sv
module fp_tricmp
   import fp_tricmp_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int RES_W    = 32,
   parameter int SP_EXP_W = 8,
   parameter int SP_MAN_W = 23,
   parameter int DP_EXP_W = 11,
   parameter int DP_MAN_W = 52
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              in_valid_i,
   input  logic [1:0]        mode_i,
   input  logic              bias_hi_i,
   input  logic [DATA_W-1:0] opa_i,
   input  logic [DATA_W-1:0] opb_i,
   output logic              out_valid_o,
   output logic [RES_W-1:0]  result_o
);

   localparam int NUM_FP = 2;
   localparam int SP_W   = 1 + SP_EXP_W + SP_MAN_W;
   localparam int DP_W   = 1 + DP_EXP_W + DP_MAN_W;

   if (DATA_W < DP_W || DATA_W < SP_W) begin : g_bad_data
      $error("fp_tricmp: operand width narrower than a float format");
   end
   if (RES_W < 2) begin : g_bad_res
      $error("fp_tricmp: result width cannot hold -1 and +1");
   end

   order_e [NUM_FP-1:0] fp_ord;
   order_e              int_ord;
   order_e              cur_ord;

   // Float lanes: lane 0 single, lane 1 double, each reading the low bits.
   for (genvar g = 0; g < NUM_FP; g++) begin : g_fp
      localparam int EW = (g == 0) ? SP_EXP_W : DP_EXP_W;
      localparam int MW = (g == 0) ? SP_MAN_W : DP_MAN_W;
      fp_order #(.EXP_W(EW), .MAN_W(MW)) u_lane (
         .a_i  (opa_i[EW+MW:0]),
         .b_i  (opb_i[EW+MW:0]),
         .ord_o(fp_ord[g])
      );
   end

   int_order #(.W(DATA_W)) u_int (
      .a_i  (opa_i),
      .b_i  (opb_i),
      .ord_o(int_ord)
   );

   always_comb begin
      if (mode_i[1]) begin
         cur_ord = int_ord;
      end else if (mode_i == MODE_DP) begin
         cur_ord = fp_ord[1];
      end else begin
         cur_ord = fp_ord[0];
      end
   end

   function automatic logic [RES_W-1:0] encode(order_e ord, logic hi);
      logic [RES_W-1:0] plus_one;
      plus_one = '0;
      plus_one[0] = 1'b1;
      case (ord)
         ORD_LT:  encode = '1;
         ORD_EQ:  encode = '0;
         ORD_GT:  encode = plus_one;
         default: encode = hi ? plus_one : '1;
      endcase
   endfunction

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         out_valid_o <= 1'b0;
         result_o    <= '0;
      end else begin
         out_valid_o <= in_valid_i;
         if (in_valid_i) begin
            result_o <= encode(cur_ord, bias_hi_i);
         end
      end
   end

   assert_valid_rise_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i |=> out_valid_o);

   assert_valid_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid_i |=> !out_valid_o);

   assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid_i |=> $stable(result_o));

   assert_legal_value_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |-> (result_o == '0 || result_o == '1 ||
                       result_o == {{(RES_W-1){1'b0}}, 1'b1}));

   assert_nan_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && !mode_i[1] && cur_ord == ORD_UN && bias_hi_i)
         |=> result_o == {{(RES_W-1){1'b0}}, 1'b1});

   assert_nan_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && !mode_i[1] && cur_ord == ORD_UN && !bias_hi_i)
         |=> result_o == '1);

   assert_int_ordered_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (in_valid_i && mode_i[1]) |-> cur_ord != ORD_UN);

endmodule

// File: tb/fp_tricmp_tb.sv
module fp_tricmp_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic        bias_hi = 1'b0;
   logic [63:0] opa = '0;
   logic [63:0] opb = '0;
   logic        out_valid;
   logic [31:0] result;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   localparam logic [31:0] M1 = 32'hFFFF_FFFF;
   localparam logic [31:0] Z0 = 32'h0000_0000;
   localparam logic [31:0] P1 = 32'h0000_0001;

   // {tag, mode, bias, a, b, expected}
   localparam int NV = 27;
   localparam logic [166:0] VECS [NV] = '{
      {4'd2,  2'd0, 1'b0, 64'h0000_0000_3F80_0000, 64'h0000_0000_3F80_0000, Z0}, // R2
      {4'd3,  2'd0, 1'b0, 64'h0000_0000_3F80_0000, 64'h0000_0000_4000_0000, M1}, // R3
      {4'd3,  2'd0, 1'b1, 64'h0000_0000_4000_0000, 64'h0000_0000_3F80_0000, P1}, // R3
      {4'd3,  2'd0, 1'b0, 64'h0000_0000_BF80_0000, 64'h0000_0000_3F80_0000, M1}, // R3
      {4'd4,  2'd0, 1'b1, 64'h0000_0000_7FC0_0000, 64'h0000_0000_3F80_0000, P1}, // R4
      {4'd5,  2'd0, 1'b0, 64'h0000_0000_7FC0_0000, 64'h0000_0000_3F80_0000, M1}, // R5
      {4'd5,  2'd0, 1'b0, 64'h0000_0000_3F80_0000, 64'h0000_0000_7FC0_0000, M1}, // R5
      {4'd4,  2'd0, 1'b1, 64'h0000_0000_7FC0_0000, 64'h0000_0000_7FC0_0000, P1}, // R4
      {4'd6,  2'd0, 1'b0, 64'h0000_0000_0000_0000, 64'h0000_0000_8000_0000, Z0}, // R6
      {4'd7,  2'd0, 1'b0, 64'h0000_0000_7F80_0000, 64'h0000_0000_4000_0000, P1}, // R7
      {4'd7,  2'd0, 1'b1, 64'h0000_0000_FF80_0000, 64'h0000_0000_FF80_0000, Z0}, // R7
      {4'd7,  2'd0, 1'b1, 64'h0000_0000_FF80_0000, 64'h0000_0000_BF80_0000, M1}, // R7
      {4'd12, 2'd0, 1'b0, 64'hDEAD_BEEF_3F80_0000, 64'h0000_0000_3F80_0000, Z0}, // R12
      {4'd2,  2'd1, 1'b0, 64'h3FF0_0000_0000_0000, 64'h3FF0_0000_0000_0000, Z0}, // R2
      {4'd3,  2'd1, 1'b1, 64'hC000_0000_0000_0000, 64'h3FF0_0000_0000_0000, M1}, // R3
      {4'd3,  2'd1, 1'b0, 64'h4000_0000_0000_0000, 64'h3FF0_0000_0000_0000, P1}, // R3
      {4'd3,  2'd1, 1'b0, 64'hBFF0_0000_0000_0000, 64'hC000_0000_0000_0000, P1}, // R3
      {4'd4,  2'd1, 1'b1, 64'h7FF8_0000_0000_0000, 64'h3FF0_0000_0000_0000, P1}, // R4
      {4'd5,  2'd1, 1'b0, 64'h3FF0_0000_0000_0000, 64'h7FF0_0000_0000_0001, M1}, // R5
      {4'd7,  2'd1, 1'b0, 64'h7FF0_0000_0000_0000, 64'h7FEF_FFFF_FFFF_FFFF, P1}, // R7
      {4'd6,  2'd1, 1'b1, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0000, Z0}, // R6
      {4'd8,  2'd2, 1'b0, 64'h7FF8_0000_0000_0000, 64'h0000_0000_0000_0001, P1}, // R8
      {4'd8,  2'd2, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, M1}, // R8
      {4'd8,  2'd2, 1'b1, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, M1}, // R8
      {4'd8,  2'd3, 1'b1, 64'h0000_0000_0000_0005, 64'h0000_0000_0000_0005, Z0}, // R8
      {4'd1,  2'd1, 1'b0, 64'h0000_0000_7FC0_0000, 64'h0000_0000_0000_0000, P1}, // R1
      {4'd1,  2'd0, 1'b0, 64'hFFFF_0000_4000_0000, 64'h0000_0000_3F80_0000, P1}  // R1
   };

   fp_tricmp u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .in_valid_i (in_valid),
      .mode_i     (mode),
      .bias_hi_i  (bias_hi),
      .opa_i      (opa),
      .opb_i      (opb),
      .out_valid_o(out_valid),
      .result_o   (result)
   );

   always #4 clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(8 * 100000);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] held;
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 out_valid in reset", {31'd0, out_valid}, 32'd0);
      check("R10 result in reset", result, Z0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 result after reset", result, Z0);
      check("R9 idle out_valid", {31'd0, out_valid}, 32'd0);

      // Vector table, back to back
      for (int i = 0; i <= NV; i++) begin
         @(negedge clk);
         if (i > 0) begin
            check($sformatf("R%0d vector %0d", VECS[i-1][166:163], i - 1),
                  result, VECS[i-1][31:0]);
            check("R9 out_valid back-to-back", {31'd0, out_valid}, 32'd1);
         end
         if (i < NV) begin
            in_valid = 1'b1;
            mode     = VECS[i][162:161];
            bias_hi  = VECS[i][160];
            opa      = VECS[i][159:96];
            opb      = VECS[i][95:32];
         end else begin
            in_valid = 1'b0;
         end
      end

      // R11: operand changes without a request leave the result alone
      held = result;
      mode = 2'b10;
      opa  = 64'h0000_0000_0000_0000;
      opb  = 64'h0000_0000_0000_0009;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check("R11 result held", result, held);
         check("R9 out_valid low without request", {31'd0, out_valid}, 32'd0);
      end

      // R9: single request after idle gives exactly one valid cycle
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R8 single request result", result, M1);
      check("R9 single pulse high", {31'd0, out_valid}, 32'd1);
      @(negedge clk);
      check("R9 single pulse low", {31'd0, out_valid}, 32'd0);

      // R12: upper bits of single operands differ wildly
      mode = 2'b00; bias_hi = 1'b1;
      opa = 64'h1234_5678_BF80_0000;
      opb = 64'hFFFF_FFFF_BF80_0000;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R12 upper bits ignored", result, Z0);

      // R10: reset mid-run clears the output
      rst_n = 1'b0;
      @(negedge clk);
      check("R10 out_valid on reset", {31'd0, out_valid}, 32'd0);
      check("R10 result on reset", result, Z0);
      rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end

endmodule